// File: doc/BRIEF.md
# In-Group Store-to-Load Resolver

This block settles memory ordering among the memory slots of one instruction group, so that concurrent evaluation gives exactly the outcome of running the slots one after another in slot order. Each slot carries an enable, an operation (load or store), a full-word address and store data. For every enabled load the block returns the data of the closest earlier enabled store to the same address in the group, or flags a miss so the caller reads backing memory instead.

It also reduces the group's stores to a final write set. For each distinct address, only the last enabled store keeps its commit enable. Stores that a later store to the same address overrides are dropped. Read-after-write, write-after-write and write-after-read patterns inside a group are all legal and are resolved, never rejected.

The block registers its results. A group presented with `valid_i` high appears on the outputs one clock later, qualified by `valid_o`. Groups may be presented back to back.

Top module: `grp_mem_resolver`

## Requirements
- R1: While `rst_ni` is low and after its release, with no group offered, `valid_o`, `ld_hit_o`, `ld_miss_o` and `commit_en_o` are all zero.
- R2: `valid_o` equals `valid_i` of the previous clock. When `valid_o` is low, every hit, miss and commit flag is zero.
- R3: An enabled load (`slot_is_store_i[i]`=0) that has an earlier enabled store (`slot_is_store_i[j]`=1, j<i) to an equal address has `ld_hit_o[i]`=1 and `ld_miss_o[i]`=0. Its `ld_data_o` lane (bits i*DATA_W and up) carries the data of the highest-indexed such store.
- R4: An enabled load with no earlier enabled store to its address has `ld_miss_o[i]`=1, `ld_hit_o[i]`=0 and a data lane of zero.
- R5: A store at a higher slot index than a load never changes that load's hit, miss or data, even when the addresses are equal.
- R6: An enabled store has `commit_en_o[j]`=1 exactly when no higher-indexed enabled store has an equal address. When it is set, `commit_addr_o` and `commit_data_o` lane j hold that store's address and data. No two set commit enables share an address.
- R7: A disabled slot has all its flags at zero and a data lane of zero. A disabled store neither forwards to loads nor clears the commit enable of an earlier store.
- R8: A store slot never raises `ld_hit_o` or `ld_miss_o`, and its `ld_data_o` lane is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A group is presented this cycle |
| slot_en_i | input | NUM_SLOTS | Per-slot enable |
| slot_is_store_i | input | NUM_SLOTS | 1 = store, 0 = load |
| slot_addr_i | input | NUM_SLOTS*ADDR_W | Slot addresses, slot i in lane i |
| slot_data_i | input | NUM_SLOTS*DATA_W | Store data, slot i in lane i |
| valid_o | output | 1 | Results of the previous cycle's group are valid |
| ld_hit_o | output | NUM_SLOTS | Load was forwarded from an in-group store |
| ld_miss_o | output | NUM_SLOTS | Load must read backing memory |
| ld_data_o | output | NUM_SLOTS*DATA_W | Forwarded load data, zero otherwise |
| commit_en_o | output | NUM_SLOTS | Store belongs to the final write set |
| commit_addr_o | output | NUM_SLOTS*ADDR_W | Address for each committing store |
| commit_data_o | output | NUM_SLOTS*DATA_W | Data for each committing store |

## Verification
The bench goes after chains of stores to one address. A design that scans in the wrong direction would forward the oldest store's data, and it would commit a superseded store alongside the last one. Groups with a load ahead of a store to the same address catch a design that forwards from later slots; that design would report a hit where a miss is due. Disabled stores placed between a matching store and a load, or after an otherwise final store, expose a design that ignores the enable: it would forward stale data or drop a legitimate commit. Back-to-back random groups over a narrow address range compare every output against a serial-execution model.

// File: rtl/grp_mem_pkg.sv
package grp_mem_pkg;
  typedef enum logic {
    OP_LD = 1'b0,
    OP_ST = 1'b1
  } mem_op_e;
endpackage

// File: rtl/grp_fwd_select.sv
module grp_fwd_select
  import grp_mem_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int IDX       = 0
) (
  input  logic [NUM_SLOTS-1:0]        en_i,
  input  logic [NUM_SLOTS-1:0]        is_store_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] addr_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] data_i,
  output logic                        hit_o,
  output logic                        miss_o,
  output logic [DATA_W-1:0]           data_o
);
  logic              match;
  logic [DATA_W-1:0] fwd;
  logic              is_ld;

  // later matching store overrides earlier: serial order
  always_comb begin
    match = 1'b0;
    fwd   = '0;
    for (int j = 0; j < IDX; j++) begin
      if (en_i[j] && (mem_op_e'(is_store_i[j]) == OP_ST) &&
          (addr_i[j*ADDR_W +: ADDR_W] == addr_i[IDX*ADDR_W +: ADDR_W])) begin
        match = 1'b1;
        fwd   = data_i[j*DATA_W +: DATA_W];
      end
    end
  end

  assign is_ld  = en_i[IDX] && (mem_op_e'(is_store_i[IDX]) == OP_LD);
  assign hit_o  = is_ld && match;
  assign miss_o = is_ld && !match;
  assign data_o = hit_o ? fwd : '0;
endmodule

// File: rtl/grp_store_prune.sv
module grp_store_prune
  import grp_mem_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16
) (
  input  logic [NUM_SLOTS-1:0]        en_i,
  input  logic [NUM_SLOTS-1:0]        is_store_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] addr_i,
  output logic [NUM_SLOTS-1:0]        keep_o
);
  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
    logic keep;
    always_comb begin
      keep = en_i[j] && (mem_op_e'(is_store_i[j]) == OP_ST);
      for (int k = j + 1; k < NUM_SLOTS; k++) begin
        if (en_i[k] && (mem_op_e'(is_store_i[k]) == OP_ST) &&
            (addr_i[k*ADDR_W +: ADDR_W] == addr_i[j*ADDR_W +: ADDR_W]))
          keep = 1'b0;
      end
    end
    assign keep_o[j] = keep;
  end
endmodule

// File: rtl/grp_mem_resolver.sv
module grp_mem_resolver
  import grp_mem_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [NUM_SLOTS-1:0]        slot_en_i,
  input  logic [NUM_SLOTS-1:0]        slot_is_store_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] slot_data_i,
  output logic                        valid_o,
  output logic [NUM_SLOTS-1:0]        ld_hit_o,
  output logic [NUM_SLOTS-1:0]        ld_miss_o,
  output logic [NUM_SLOTS*DATA_W-1:0] ld_data_o,
  output logic [NUM_SLOTS-1:0]        commit_en_o,
  output logic [NUM_SLOTS*ADDR_W-1:0] commit_addr_o,
  output logic [NUM_SLOTS*DATA_W-1:0] commit_data_o
);
  localparam int AW_ALL = NUM_SLOTS * ADDR_W;
  localparam int DW_ALL = NUM_SLOTS * DATA_W;

  logic [NUM_SLOTS-1:0] hit_c, miss_c, keep_c;
  logic [DW_ALL-1:0]    data_c;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ld
    grp_fwd_select #(
      .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX(i)
    ) u_fwd (
      .en_i      (slot_en_i),
      .is_store_i(slot_is_store_i),
      .addr_i    (slot_addr_i),
      .data_i    (slot_data_i),
      .hit_o     (hit_c[i]),
      .miss_o    (miss_c[i]),
      .data_o    (data_c[i*DATA_W +: DATA_W])
    );
  end

  grp_store_prune #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_prune (
    .en_i      (slot_en_i),
    .is_store_i(slot_is_store_i),
    .addr_i    (slot_addr_i),
    .keep_o    (keep_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      ld_hit_o      <= '0;
      ld_miss_o     <= '0;
      ld_data_o     <= '0;
      commit_en_o   <= '0;
      commit_addr_o <= '0;
      commit_data_o <= '0;
    end else begin
      valid_o     <= valid_i;
      ld_hit_o    <= valid_i ? hit_c  : '0;
      ld_miss_o   <= valid_i ? miss_c : '0;
      commit_en_o <= valid_i ? keep_c : '0;
      if (valid_i) begin
        ld_data_o     <= data_c;
        commit_addr_o <= slot_addr_i[AW_ALL-1:0];
        commit_data_o <= slot_data_i[DW_ALL-1:0];
      end
    end
  end

  // R2
  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (ld_hit_o == '0 && ld_miss_o == '0 && commit_en_o == '0));
  // R3/R4: flags mutually exclusive
  p_hit_miss_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hit_o & ld_miss_o) == '0);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    p_load_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(valid_i && slot_en_i[i] && !slot_is_store_i[i]) |-> (ld_hit_o[i] || ld_miss_o[i]));
    p_store_no_ld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_en_o[i] |-> !(ld_hit_o[i] || ld_miss_o[i]));
    for (genvar k = i + 1; k < NUM_SLOTS; k++) begin : g_pair
      p_commit_unique_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_en_o[i] && commit_en_o[k]) |->
        (commit_addr_o[i*ADDR_W +: ADDR_W] != commit_addr_o[k*ADDR_W +: ADDR_W]));
    end
  end
endmodule

// File: tb/tb_grp_mem_resolver.sv
module tb_grp_mem_resolver;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [N-1:0]    en_i = '0, st_i = '0;
  logic [N*AW-1:0] addr_i = '0;
  logic [N*DW-1:0] data_i = '0;
  logic            valid_o;
  logic [N-1:0]    hit_o, miss_o, cen_o;
  logic [N*DW-1:0] ldat_o, cdat_o;
  logic [N*AW-1:0] caddr_o;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic [N-1:0]    hit, miss, cen, en, st;
    logic [N*DW-1:0] ldat, sdat;
    logic [N*AW-1:0] addr;
    string           tag;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;

  grp_mem_resolver #(.NUM_SLOTS(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .slot_en_i(en_i), .slot_is_store_i(st_i), .slot_addr_i(addr_i), .slot_data_i(data_i),
    .valid_o(valid_o), .ld_hit_o(hit_o), .ld_miss_o(miss_o), .ld_data_o(ldat_o),
    .commit_en_o(cen_o), .commit_addr_o(caddr_o), .commit_data_o(cdat_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // serial-execution reference model
  function automatic exp_t model(input logic [N-1:0] en, st, input logic [N*AW-1:0] a,
                                 input logic [N*DW-1:0] d, input string tag);
    exp_t e;
    logic [DW-1:0] mem_d[logic [AW-1:0]];
    int            last_wr[logic [AW-1:0]];
    e.hit = '0; e.miss = '0; e.cen = '0; e.ldat = '0;
    e.en = en; e.st = st; e.addr = a; e.sdat = d; e.tag = tag;
    for (int i = 0; i < N; i++) begin
      if (!en[i]) continue;
      if (st[i]) begin
        mem_d[a[i*AW +: AW]]   = d[i*DW +: DW];
        last_wr[a[i*AW +: AW]] = i;
      end else if (mem_d.exists(a[i*AW +: AW])) begin
        e.hit[i] = 1'b1;
        e.ldat[i*DW +: DW] = mem_d[a[i*AW +: AW]];
      end else begin
        e.miss[i] = 1'b1;
      end
    end
    for (int i = 0; i < N; i++)
      if (en[i] && st[i] && last_wr[a[i*AW +: AW]] == i) e.cen[i] = 1'b1;
    return e;
  endfunction

  // drive at negedge for one cycle, push expectation
  task automatic drive(input logic [N-1:0] en, st, input logic [N*AW-1:0] a,
                       input logic [N*DW-1:0] d, input string tag);
    @(negedge clk);
    valid_i = 1'b1; en_i = en; st_i = st; addr_i = a; data_i = d;
    sbq.push_back(model(en, st, a, d, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0; en_i = '0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        exp_t e;
        if (sbq.size() == 0) begin
          chk(0, "R2 unexpected valid_o", 1, 0);
        end else begin
          e = sbq.pop_front();
          for (int i = 0; i < N; i++) begin
            string req;
            if (!e.en[i]) req = "R7";
            else if (e.st[i]) req = "R8";
            else if (e.hit[i]) req = "R3";
            else req = "R4";
            req = {req, " ", e.tag};
            chk(hit_o[i] == e.hit[i], {req, " hit"}, 64'(hit_o[i]), 64'(e.hit[i]));
            chk(miss_o[i] == e.miss[i], {req, " miss"}, 64'(miss_o[i]), 64'(e.miss[i]));
            chk(ldat_o[i*DW +: DW] == e.ldat[i*DW +: DW], {req, " data"},
                64'(ldat_o[i*DW +: DW]), 64'(e.ldat[i*DW +: DW]));
            chk(cen_o[i] == e.cen[i], {"R6 commit_en ", e.tag}, 64'(cen_o[i]), 64'(e.cen[i]));
            if (e.cen[i]) begin
              chk(caddr_o[i*AW +: AW] == e.addr[i*AW +: AW], "R6 commit_addr",
                  64'(caddr_o[i*AW +: AW]), 64'(e.addr[i*AW +: AW]));
              chk(cdat_o[i*DW +: DW] == e.sdat[i*DW +: DW], "R6 commit_data",
                  64'(cdat_o[i*DW +: DW]), 64'(e.sdat[i*DW +: DW]));
            end
          end
        end
      end else if (rst_n && done == 0 && sbq.size() == 0) begin
        // idle outputs quiet
        if (hit_o != '0 || miss_o != '0 || cen_o != '0) chk(0, "R2 idle flags", 64'(cen_o), 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(valid_o == 0, "R1 valid", 64'(valid_o), 0);
    chk((hit_o | miss_o | cen_o) == '0, "R1 flags", 64'(hit_o | miss_o | cen_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid_o == 0, "R1 valid after release", 64'(valid_o), 0);
    chk((hit_o | miss_o | cen_o) == '0, "R1 flags after release", 64'(hit_o | miss_o | cen_o), 0);

    // slot order 3..0 in literals: {s3,s2,s1,s0}
    // R3 RAW: st A, ld A, st B, ld B
    drive(4'hF, 4'b0101, {16'h00B0, 16'h00B0, 16'h00A0, 16'h00A0},
          {32'h0, 32'hBBBB0001, 32'h0, 32'hAAAA0001}, "R3 raw");
    idle();
    // R2 latency: valid_o rose exactly one cycle after drive
    chk(valid_o == 1, "R2 latency", 64'(valid_o), 1);
    @(negedge clk);
    chk(valid_o == 0, "R2 drop", 64'(valid_o), 0);
    // R6 WAW chain: st A d1, st A d2, ld A, st A d3
    drive(4'hF, 4'b1011, {16'h00A0, 16'h00A0, 16'h00A0, 16'h00A0},
          {32'hD3, 32'h0, 32'hD2, 32'hD1}, "R6 waw");
    // R5 WAR: ld A, st A, ld A, st C
    drive(4'hF, 4'b1010, {16'h00C0, 16'h00A0, 16'h00A0, 16'h00A0},
          {32'hC5, 32'h0, 32'hD5, 32'h0}, "R5 war");
    // R4 no matches
    drive(4'hF, 4'b0100, {16'h00D0, 16'h00C0, 16'h00B0, 16'h00A0},
          {32'h0, 32'h77, 32'h0, 32'h0}, "R4 nomatch");
    // R7 disabled store between: st A(off), ld A, st B, st B(off)
    drive(4'b0110, 4'b1101, {16'h00B0, 16'h00B0, 16'h00A0, 16'h00A0},
          {32'hEE, 32'hBB, 32'h0, 32'h11}, "R7 disabled");
    // R7 disabled later store must not supersede; disabled load silent
    drive(4'b0011, 4'b1011, {16'h00A0, 16'h00A0, 16'h00A0, 16'h00A0},
          {32'h99, 32'h0, 32'h22, 32'h21}, "R7 nosupersede");
    // back-to-back random groups, narrow address range
    for (int g = 0; g < 40; g++) begin
      logic [N*AW-1:0] a;
      logic [N*DW-1:0] d;
      for (int s = 0; s < N; s++) begin
        a[s*AW +: AW] = AW'($urandom_range(0, 2));
        d[s*DW +: DW] = $urandom;
      end
      drive(N'($urandom), N'($urandom), a, d, "R3 random");
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    chk(sbq.size() == 0, "R2 all results seen", 64'(sbq.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule